// File: doc/BRIEF.md
# Half-Pel Block Motion Predictor

This block builds an 8x8 block of predicted 8-bit pixels from a window of reference pixels. A start pulse latches one of four prediction types and a rounding flag. Reference rows then arrive one per beat on a valid/ready input stream, each 9 pixels wide. Predicted rows leave one per beat, 8 pixels wide, on a valid/ready output stream, top row first.

The vertical and diagonal types need the row below each output row. The block therefore keeps state from the previous reference row, so every reference row is read exactly once. For the diagonal type it keeps each horizontal pair's half-sum and the least significant bit of its XOR. It then forms the four-pixel average from these stored terms and the current row's terms, and never builds a full four-input sum.

Pixel k of a row sits at bits [8k+7:8k]. Pixel 0 is the leftmost, and its right neighbour is pixel k+1.

Top module: `halfpel_pred`

## Requirements
- R1: A start pulse while idle latches `mode` (0 copy, 1 horizontal, 2 vertical, 3 diagonal) and `trunc`. A start pulse while a block is in progress is ignored, and the running block keeps its original type and flag.
- R2: Mode 0 outputs pixels 0..7 of each reference row unchanged, and `trunc` has no effect on the result.
- R3: Mode 1 outputs the average of pixel k and pixel k+1 of the same reference row.
- R4: Mode 2 outputs the average of pixel k in reference row r and pixel k in row r+1. The first reference row produces no output.
- R5: Mode 3 outputs the average of pixels k and k+1 in rows r and r+1. The result is bit-exact for every input value, including all-255 inputs.
- R6: With `trunc`=0, a two-pixel average is (a+b+1)>>1 and a four-pixel average is (a+b+c+d+2)>>2. With `trunc`=1 they are (a+b)>>1 and (a+b+c+d+1)>>2.
- R7: Modes 0 and 1 accept exactly 8 reference rows per block. Modes 2 and 3 accept exactly 9. `ref_ready` stays low once the count is reached and while idle.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_row` holds its value.
- R9: `done` is high for exactly one cycle, in the cycle after the 8th output row is accepted. The block is idle from that cycle on.
- R10: `ref_ready` is low whenever an output row is pending and `out_ready` is low, so a pending row is never overwritten.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a block, latching mode and trunc |
| mode | input | 2 | Prediction type code |
| trunc | input | 1 | 0 = round-up bias, 1 = truncating bias |
| ref_valid | input | 1 | Reference row available |
| ref_ready | output | 1 | Block accepts a reference row |
| ref_row | input | 72 | Nine reference pixels |
| out_valid | output | 1 | Predicted row available |
| out_ready | input | 1 | Consumer accepts the predicted row |
| out_row | output | 64 | Eight predicted pixels |
| done | output | 1 | One-cycle pulse after the last row is accepted |

## Verification
The assertions check the stream rules on every cycle: a pending row is held steady under backpressure, input is refused while an output is stuck, `done` follows an output handshake, and the number of reference beats in a block matches the mode. The arithmetic can only be shown by the bench's scenarios. These sweep every mode and both rounding settings over saturated, zero, checkerboard and random windows, with and without stalls on both streams, against per-pixel formulas. One scenario also pulses start in the middle of a block and confirms from the predicted rows that the original type was kept.

// File: rtl/halfpel_pred.sv
module halfpel_pred #(
  parameter int PW = 8,
  parameter int N  = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [1:0]            mode,
  input  logic                  trunc,
  input  logic                  ref_valid,
  output logic                  ref_ready,
  input  logic [(N+1)*PW-1:0]   ref_row,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [N*PW-1:0]       out_row,
  output logic                  done
);
  localparam int CW = $clog2(N + 2);

  logic                   busy;
  logic [1:0]             mode_q;
  logic                   trunc_q;
  logic [CW-1:0]          in_cnt, out_cnt, need;
  logic [N-1:0][PW-1:0]   prev_s, nxt_s, res;
  logic [N-1:0]           prev_e, nxt_e;
  logic                   in_fire, out_fire, first_row, rb;

  assign need      = mode_q[1] ? CW'(N + 1) : CW'(N);
  assign first_row = mode_q[1] && (in_cnt == '0);
  assign ref_ready = busy && (in_cnt < need) && (!out_valid || out_ready);
  assign in_fire   = ref_valid && ref_ready;
  assign out_fire  = out_valid && out_ready;
  assign rb        = ~trunc_q;

  for (genvar k = 0; k < N; k++) begin : g_px
    logic [PW-1:0] a, b, s, dg;
    logic [PW:0]   ab, hs, vs, ds;
    logic          x0, corr;
    assign a    = ref_row[k*PW +: PW];
    assign b    = ref_row[(k+1)*PW +: PW];
    assign ab   = {1'b0, a} + {1'b0, b};
    assign s    = PW'(ab >> 1);
    assign hs   = ab + {{PW{1'b0}}, rb};
    assign vs   = {1'b0, prev_s[k]} + {1'b0, a} + {{PW{1'b0}}, rb};
    assign ds   = {1'b0, prev_s[k]} + {1'b0, s};
    assign x0   = prev_s[k][0] ^ s[0];
    assign corr = trunc_q ? ((prev_e[k] | nxt_e[k]) & x0)
                          : ((prev_e[k] & nxt_e[k]) | x0);
    assign dg   = PW'(ds >> 1) + PW'(corr);
    assign nxt_e[k] = a[0] ^ b[0];
    assign nxt_s[k] = (mode_q == 2'd2) ? a : s;
    assign res[k]   = (mode_q == 2'd0) ? a :
                      (mode_q == 2'd1) ? PW'(hs >> 1) :
                      (mode_q == 2'd2) ? PW'(vs >> 1) : dg;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      mode_q    <= '0;
      trunc_q   <= 1'b0;
      in_cnt    <= '0;
      out_cnt   <= '0;
      prev_s    <= '0;
      prev_e    <= '0;
      out_valid <= 1'b0;
      out_row   <= '0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        busy    <= 1'b1;
        mode_q  <= mode;
        trunc_q <= trunc;
        in_cnt  <= '0;
        out_cnt <= '0;
      end
      if (in_fire) begin
        in_cnt <= in_cnt + 1'b1;
        prev_s <= nxt_s;
        prev_e <= nxt_e;
      end
      if (in_fire && !first_row) begin
        out_valid <= 1'b1;
        out_row   <= res;
      end else if (out_fire) begin
        out_valid <= 1'b0;
      end
      if (out_fire) begin
        out_cnt <= out_cnt + 1'b1;
        if (out_cnt == CW'(N - 1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/halfpel_pred_chk.sv
module halfpel_pred_chk #(
  parameter int N  = 8,
  parameter int OW = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic [1:0]    mode_q,
  input logic          ref_valid,
  input logic          ref_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [OW-1:0] out_row,
  input logic          done
);
  localparam int BW = $clog2(N + 2) + 1;
  logic [BW-1:0] beats;

  always_ff @(posedge clk) begin
    if (!rst_n)                  beats <= '0;
    else if (start && !busy)     beats <= '0;
    else if (ref_valid && ref_ready) beats <= beats + 1'b1;
  end

  // R8
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_row));

  // R10
  no_overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !ref_ready);

  // R9
  done_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(out_valid && out_ready) && !busy);

  // R7
  beat_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> beats == (mode_q[1] ? BW'(N + 1) : BW'(N)));

  // R7
  idle_no_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !ref_ready);
endmodule

bind halfpel_pred halfpel_pred_chk #(.N(N), .OW(N*PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .mode_q(mode_q),
  .ref_valid(ref_valid), .ref_ready(ref_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_row(out_row), .done(done));

// File: tb/tb_halfpel_pred.sv
module tb_halfpel_pred;
  logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0, trunc = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic        ref_valid = 1'b0, out_ready = 1'b0;
  logic [71:0] ref_row = '0;
  logic        ref_ready, out_valid, done;
  logic [63:0] out_row;

  int tests = 0, fails = 0;
  int px [0:8][0:8];

  always #10 clk = ~clk;

  halfpel_pred dut (.clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .trunc(trunc),
    .ref_valid(ref_valid), .ref_ready(ref_ready), .ref_row(ref_row),
    .out_valid(out_valid), .out_ready(out_ready), .out_row(out_row), .done(done));

  function automatic string mreq(int m);
    case (m)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      default: return "R5";
    endcase
  endfunction

  function automatic logic [63:0] expect_row(int m, int t, int r);
    logic [63:0] v;
    for (int c = 0; c < 8; c++) begin
      int e;
      case (m)
        0: e = px[r][c];
        1: e = (px[r][c] + px[r][c+1] + (t ? 0 : 1)) >> 1;
        2: e = (px[r][c] + px[r+1][c] + (t ? 0 : 1)) >> 1;
        default: e = (px[r][c] + px[r][c+1] + px[r+1][c] + px[r+1][c+1] + (t ? 1 : 2)) >> 2;
      endcase
      v[c*8 +: 8] = 8'(e);
    end
    return v;
  endfunction

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_block(int m, int t, int pat, bit bp, bit poke);
    int need, in_i, out_i, cyc;
    bit done_due, fin, held;
    logic [63:0] held_row;
    string tag;
    for (int r = 0; r < 9; r++)
      for (int c = 0; c < 9; c++)
        case (pat)
          0: px[r][c] = 255;
          1: px[r][c] = 0;
          2: px[r][c] = ((r + c) % 2) ? 255 : (r * 9 + c) % 7;
          default: px[r][c] = $urandom_range(0, 255);
        endcase
    tag = poke ? "R1" : mreq(m);
    if (m != 0) tag = {tag, "/R6"};
    @(negedge clk);
    start = 1'b1; mode = 2'(m); trunc = t[0];
    @(negedge clk);
    start = 1'b0;
    need = (m >= 2) ? 9 : 8;
    in_i = 0; out_i = 0; cyc = 0; done_due = 0; fin = 0; held = 0; held_row = '0;
    while (!fin) begin
      if (done_due) begin
        check(done === 1'b1 && out_valid === 1'b0, "R9 done", {63'd0, done}, 64'd1);
        done_due = 0; fin = 1;
      end else if (done === 1'b1) begin
        check(1'b0, "R9 early done", 64'd1, 64'd0);
      end
      if (held) begin
        check(out_valid === 1'b1 && out_row === held_row, "R8", out_row, held_row);
        held = 0;
      end
      if (!fin) begin
        ref_valid = (in_i < need) && (!bp || ($urandom_range(0, 3) != 0));
        for (int c = 0; c < 9; c++) ref_row[c*8 +: 8] = (in_i < 9) ? 8'(px[in_i][c]) : 8'd0;
        out_ready = !bp || ($urandom_range(0, 2) != 0);
        if (poke && in_i == 3) begin
          start = 1'b1; mode = 2'(m + 1); trunc = ~t[0];
        end else start = 1'b0;
        #1;
        if (out_valid && !out_ready) begin
          check(ref_ready === 1'b0, "R10", {63'd0, ref_ready}, 64'd0);
          held = 1; held_row = out_row;
        end
        if (ref_valid && ref_ready) in_i++;
        if (out_valid && out_ready) begin
          logic [63:0] ex;
          ex = expect_row(m, t, out_i);
          check(out_row === ex, $sformatf("%s mode%0d trunc%0d row%0d", tag, m, t, out_i), out_row, ex);
          out_i++;
          if (out_i == 8) done_due = 1;
        end
        cyc++;
        if (cyc > 2000) begin
          check(1'b0, "R7 stuck block", 64'(in_i), 64'(need));
          fin = 1;
        end
        @(negedge clk);
      end
    end
    start = 1'b0; ref_valid = 1'b0;
    #1;
    check(in_i == need && ref_ready === 1'b0, "R7 beat count", 64'(in_i), 64'(need));
  endtask

  initial begin
    #(20ns * 200000);
    fails++; tests++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid === 1'b0 && ref_ready === 1'b0 && done === 1'b0, "R1 reset idle",
          {61'd0, out_valid, ref_ready, done}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    ref_valid = 1'b1;
    #1;
    check(ref_ready === 1'b0, "R7 idle ready", {63'd0, ref_ready}, 64'd0);
    ref_valid = 1'b0;
    for (int m = 0; m < 4; m++)
      for (int t = 0; t < 2; t++)
        for (int p = 0; p < 5; p++)
          run_block(m, t, (p > 3) ? 3 : p, p[0], 1'b0);
    run_block(3, 0, 3, 1'b1, 1'b1);
    run_block(1, 1, 3, 1'b0, 1'b1);
    run_block(0, 1, 3, 1'b1, 1'b1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule